// File: doc/BRIEF.md
# Interconnect Performance Counter Unit

This block counts activity for one clock domain of an on-chip interconnect. It holds eight 32-bit event counters and one 64-bit cycle counter. Software sets it up through a 32-bit register port. Each event counter is paired with a selector register that names a source node by node type and node ID. That selector is driven out so the fabric can route the chosen node's event pulse onto the counter's input line. When any counter rolls over, it raises an overflow flag, and a single level interrupt reports the flags that are unmasked.

Software programs the unit in this order:
1. Preload the counters.
2. Write the node selectors.
3. Open the per-counter enables and interrupt enables.
4. Set the global enable.

Enables, interrupt enables and overflow flags are each a 32-bit bitmap. Bits 0 to 7 stand for event counters 0 to 7, and bit 31 stands for the cycle counter. Each bitmap has a write-one-to-set address and a write-one-to-clear address.

The register port is a valid/ready request channel followed by a response. The unit never applies back-pressure: `cmd_ready` is always high, so every request is taken in the cycle `cmd_valid` is high. A read returns its data one cycle later on `rsp_valid`/`rsp_rdata`. The response channel has no ready, so the requester must always accept it.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, all counters, bitmaps, the global enable and the selectors are zero, and `irq` and `rsp_valid` are low.
- R2: Event counter n sits at 0x008 + 8·n and can be written to preload it and read back. It adds one on a cycle where its `evt_pulse` bit is high only if the global enable (control bit 0) and its own enable bit n are both set.
- R3: A counter stepping from all-ones to zero sets its overflow flag: bit n for event counter n, bit 31 for the cycle counter.
- R4: The cycle counter is 64 bits wide, with the low word at 0x0F8 and the high word at 0x0FC. Each half can be written on its own. When enabled it adds one every clock, and a carry out of the low word shows in the high word from the next cycle.
- R5: Counter enables are set by writing ones to 0xC00 and cleared by writing ones to 0xC20. Zero bits have no effect. Both addresses read the current bitmap. Only bits 0–7 and 31 exist; the rest read 0 and ignore writes.
- R6: Interrupt enables follow the same rules at 0xC40 (set) and 0xC60 (clear).
- R7: Overflow flags are read at 0xC80 and cleared by writing ones there. Writing ones to 0xCC0 sets them. If a counter wraps in the same cycle that software clears its flag, the flag stays set.
- R8: `irq` is high exactly while some overflow flag is set together with its interrupt enable bit.
- R9: The control register is at 0xE04. Bit 0 is the global enable and is stored. Writing 1 to bit 1 zeroes every event counter once, and writing 1 to bit 2 zeroes the cycle counter once. Bits 1 and 2 always read 0.
- R10: The selector for counter n is at 0x400 + 4·n. It holds the node type in bits 12:9 and the node ID in bits 8:0, reads back with the other bits 0, and drives `sel_type[4n+:4]` and `sel_id[9n+:9]`.
- R11: The configuration word at 0xE00 reads the constant 0x00004008: counter count in bits 7:0 and cycle width in bits 15:8.
- R12: `cmd_ready` is always 1. A read gives `rsp_valid` high in the next cycle, with the state held just before that clock edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Register request present |
| cmd_ready | output | 1 | Request accepted (always 1) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 12 | Byte offset of the register |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| evt_pulse | input | 8 | One event pulse line per event counter |
| sel_type | output | 32 | Node type selector, 4 bits per counter |
| sel_id | output | 72 | Node ID selector, 9 bits per counter |
| irq | output | 1 | Level overflow interrupt |

## Verification
The key collision is a hardware counter wrap landing in the same clock edge as a software write-one-to-clear of that counter's overflow flag. The bench provokes it by preloading event counter 0 to all-ones with its flag already set. It then drives `evt_pulse[0]` and the clear write to 0xC80 in one cycle. It judges the result by reading back that the flag survived and the counter shows zero. A second overlap, the cycle counter's low-to-high carry arriving between two word reads, is covered by letting the counter run across the carry and checking the high word afterwards.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TYPE_W = 4;
  localparam int unsigned NODE_W = 9;
  localparam int unsigned CYC_BIT = 31;

  localparam logic [ADDR_W-1:0] OFF_EVT_BASE  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_CYC_LO    = 12'h0F8;
  localparam logic [ADDR_W-1:0] OFF_CYC_HI    = 12'h0FC;
  localparam logic [ADDR_W-1:0] OFF_TYPE_BASE = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_EN_SET    = 12'hC00;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR    = 12'hC20;
  localparam logic [ADDR_W-1:0] OFF_IE_SET    = 12'hC40;
  localparam logic [ADDR_W-1:0] OFF_IE_CLR    = 12'hC60;
  localparam logic [ADDR_W-1:0] OFF_OV_CLR    = 12'hC80;
  localparam logic [ADDR_W-1:0] OFF_OV_SET    = 12'hCC0;
  localparam logic [ADDR_W-1:0] OFF_CFG       = 12'hE00;
  localparam logic [ADDR_W-1:0] OFF_CTRL      = 12'hE04;

  typedef struct packed {
    logic [TYPE_W-1:0] ntype;
    logic [NODE_W-1:0] nid;
  } node_sel_t;

  function automatic logic [ADDR_W-1:0] evt_addr(input int n);
    return OFF_EVT_BASE + ADDR_W'(n * 8);
  endfunction

  function automatic logic [ADDR_W-1:0] sel_addr(input int n);
    return OFF_TYPE_BASE + ADDR_W'(n * 4);
  endfunction
endpackage

// File: rtl/pmu_bitmap.sv
module pmu_bitmap #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] set_v, clr_v;

  always_comb begin
    set_v = set_stb ? wmask : '0;
    clr_v = clr_stb ? wmask : '0;
  end

  // hardware set wins over a software clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= ((q & ~clr_v) | set_v | hw_set) & IMPL;
  end

  a_r5_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((q & $past(wmask & IMPL)) == $past(wmask & IMPL)));
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !set_stb) |=> ((q & $past(wmask & ~hw_set)) == '0));
  a_r7_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((q & $past(hw_set & IMPL)) == $past(hw_set & IMPL)));
endmodule

// File: rtl/pmu_evt_ctr.sv
module pmu_evt_ctr #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         wrap
);
  assign wrap = inc && !load && !clr && (count == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (clr)  count <= '0;
    else if (inc)  count <= count + 1'b1;
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr && !inc) |=> $stable(count));
  a_r2_preload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0));
endmodule

// File: rtl/pmu_cyc_ctr.sv
module pmu_cyc_ctr #(
  parameter int unsigned W = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_lo,
  input  logic           ld_hi,
  input  logic [W/2-1:0] wdata,
  input  logic           clr,
  input  logic           inc,
  output logic [W-1:0]   count,
  output logic           wrap
);
  localparam int unsigned HALF = W / 2;

  logic quiet;
  assign quiet = !ld_lo && !ld_hi && !clr;
  assign wrap  = inc && quiet && (count == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (ld_lo) count[HALF-1:0] <= wdata;
    else if (ld_hi) count[W-1:HALF] <= wdata;
    else if (clr)   count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  a_r4_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && quiet && (count[HALF-1:0] == '1))
      |=> (count[W-1:HALF] == $past(count[W-1:HALF]) + 1'b1));
  a_r4_lo_only: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> (count[W-1:HALF] == $past(count[W-1:HALF])));
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned EVT_W   = 32,
  parameter int unsigned CYC_W   = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic                       cmd_write,
  input  logic [11:0]                cmd_addr,
  input  logic [31:0]                cmd_wdata,
  output logic                       rsp_valid,
  output logic [31:0]                rsp_rdata,
  input  logic [NUM_EVT-1:0]         evt_pulse,
  output logic [NUM_EVT*TYPE_W-1:0]  sel_type,
  output logic [NUM_EVT*NODE_W-1:0]  sel_id,
  output logic                       irq
);
  localparam logic [DATA_W-1:0] IMPL =
    (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_EVT) - DATA_W'(1));
  localparam logic [DATA_W-1:0] CFG_WORD = {16'h0, 8'(CYC_W), 8'(NUM_EVT)};
  localparam int unsigned SEL_W = TYPE_W + NODE_W;

  logic wr, rd;
  assign cmd_ready = 1'b1;
  assign wr = cmd_valid && cmd_write;
  assign rd = cmd_valid && !cmd_write;

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return wr && (cmd_addr == a);
  endfunction

  // global control
  logic gen_en, clr_evt, clr_cyc;
  assign clr_evt = hit(OFF_CTRL) && cmd_wdata[1];
  assign clr_cyc = hit(OFF_CTRL) && cmd_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gen_en <= 1'b0;
    else if (hit(OFF_CTRL))  gen_en <= cmd_wdata[0];
  end

  // bitmaps
  logic [DATA_W-1:0] en_q, ie_q, ov_q, ov_hw;
  logic [NUM_EVT-1:0] evt_wrap;
  logic cyc_wrap;

  always_comb begin
    ov_hw = '0;
    ov_hw[NUM_EVT-1:0] = evt_wrap;
    ov_hw[CYC_BIT] = cyc_wrap;
  end

  pmu_bitmap #(.W(DATA_W), .IMPL(IMPL)) u_en (
    .clk(clk), .rst_n(rst_n), .set_stb(hit(OFF_EN_SET)), .clr_stb(hit(OFF_EN_CLR)),
    .wmask(cmd_wdata), .hw_set('0), .q(en_q));
  pmu_bitmap #(.W(DATA_W), .IMPL(IMPL)) u_ie (
    .clk(clk), .rst_n(rst_n), .set_stb(hit(OFF_IE_SET)), .clr_stb(hit(OFF_IE_CLR)),
    .wmask(cmd_wdata), .hw_set('0), .q(ie_q));
  pmu_bitmap #(.W(DATA_W), .IMPL(IMPL)) u_ov (
    .clk(clk), .rst_n(rst_n), .set_stb(hit(OFF_OV_SET)), .clr_stb(hit(OFF_OV_CLR)),
    .wmask(cmd_wdata), .hw_set(ov_hw), .q(ov_q));

  // event counters and their node selectors
  logic [EVT_W-1:0] evt_cnt [NUM_EVT];
  node_sel_t        sel_q   [NUM_EVT];

  for (genvar n = 0; n < NUM_EVT; n++) begin : g_evt
    pmu_evt_ctr #(.W(EVT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .load(hit(evt_addr(n))), .load_val(EVT_W'(cmd_wdata)),
      .clr(clr_evt), .inc(gen_en && en_q[n] && evt_pulse[n]),
      .count(evt_cnt[n]), .wrap(evt_wrap[n]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 sel_q[n] <= '0;
      else if (hit(sel_addr(n)))  sel_q[n] <= node_sel_t'(cmd_wdata[SEL_W-1:0]);
    end

    assign sel_type[n*TYPE_W +: TYPE_W] = sel_q[n].ntype;
    assign sel_id[n*NODE_W +: NODE_W]   = sel_q[n].nid;
  end

  // cycle counter
  logic [CYC_W-1:0] cyc_cnt;
  pmu_cyc_ctr #(.W(CYC_W)) u_cyc (
    .clk(clk), .rst_n(rst_n),
    .ld_lo(hit(OFF_CYC_LO)), .ld_hi(hit(OFF_CYC_HI)), .wdata(cmd_wdata),
    .clr(clr_cyc), .inc(gen_en && en_q[CYC_BIT]),
    .count(cyc_cnt), .wrap(cyc_wrap));

  // read path
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (cmd_addr)
      OFF_CYC_LO:             rd_mux = cyc_cnt[DATA_W-1:0];
      OFF_CYC_HI:             rd_mux = cyc_cnt[CYC_W-1:DATA_W];
      OFF_EN_SET, OFF_EN_CLR: rd_mux = en_q;
      OFF_IE_SET, OFF_IE_CLR: rd_mux = ie_q;
      OFF_OV_CLR, OFF_OV_SET: rd_mux = ov_q;
      OFF_CFG:                rd_mux = CFG_WORD;
      OFF_CTRL:               rd_mux = {31'b0, gen_en};
      default:                rd_mux = '0;
    endcase
    for (int n = 0; n < NUM_EVT; n++) begin
      if (cmd_addr == evt_addr(n)) rd_mux = DATA_W'(evt_cnt[n]);
      if (cmd_addr == sel_addr(n)) rd_mux = DATA_W'(sel_q[n]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end

  assign irq = |(ov_q & ie_q);

  a_r12_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  a_r12_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> !irq);
  a_r9_evt_reset: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (evt_cnt[0] == '0));
endmodule

// File: tb/perf_mon_unit_tb_top.sv
module perf_mon_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [11:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;
  logic [7:0] evt_pulse = '0;
  logic [31:0] sel_type;
  logic [71:0] sel_id;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  perf_mon_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .evt_pulse(evt_pulse),
    .sel_type(sel_type), .sel_id(sel_id), .irq(irq));

  typedef struct packed {
    logic        wr;
    logic [7:0]  req;
    logic [11:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd5,  12'hC00, 32'hFFFFFFFF},
    '{1'b0, 8'd5,  12'hC00, 32'h800000FF},  // R5 unimplemented bits read 0
    '{1'b0, 8'd5,  12'hC20, 32'h800000FF},  // R5 clear alias reads same
    '{1'b1, 8'd5,  12'hC20, 32'h0000000F},
    '{1'b0, 8'd5,  12'hC00, 32'h800000F0},  // R5 write-one-clear
    '{1'b1, 8'd5,  12'hC00, 32'h00000000},
    '{1'b0, 8'd5,  12'hC20, 32'h800000F0},  // R5 zeros have no effect
    '{1'b1, 8'd6,  12'hC40, 32'h80000003},
    '{1'b0, 8'd6,  12'hC60, 32'h80000003},  // R6
    '{1'b1, 8'd6,  12'hC60, 32'hFFFFFFFF},
    '{1'b0, 8'd6,  12'hC40, 32'h00000000},  // R6
    '{1'b1, 8'd2,  12'h010, 32'h12345678},
    '{1'b0, 8'd2,  12'h010, 32'h12345678},  // R2 preload
    '{1'b1, 8'd10, 12'h408, 32'hFFFFFFFF},
    '{1'b0, 8'd10, 12'h408, 32'h00001FFF},  // R10
    '{1'b0, 8'd11, 12'hE00, 32'h00004008},  // R11
    '{1'b0, 8'd12, 12'h100, 32'h00000000},  // R12 unmapped
    '{1'b1, 8'd4,  12'h0F8, 32'hAAAA5555},
    '{1'b0, 8'd4,  12'h0F8, 32'hAAAA5555},  // R4 low word
    '{1'b0, 8'd4,  12'h0FC, 32'h00000000}   // R4 high untouched
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R12 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic pulse(input logic [7:0] m, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk); evt_pulse = m;
      @(negedge clk); evt_pulse = '0;
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 cmd_ready", {31'b0, cmd_ready}, 1);
    bus_rd(12'hC00, v); chk("R1 enables", v, 0);
    bus_rd(12'hC80, v); chk("R1 overflow", v, 0);
    bus_rd(12'hE04, v); chk("R1 control", v, 0);
    bus_rd(12'h008, v); chk("R1 counter0", v, 0);
    bus_rd(12'h0F8, v); chk("R1 cycle low", v, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_wr(VECS[i].addr, VECS[i].data);
      else begin
        bus_rd(VECS[i].addr, v);
        checks++;
        if (v !== VECS[i].data) begin
          fails++;
          $display("FAIL R%0d vec %0d: got %08h expected %08h", VECS[i].req, i, v, VECS[i].data);
        end
      end
    end
    chk("R10 sel_type", {28'b0, sel_type[11:8]}, 32'hF);
    chk("R10 sel_id", {23'b0, sel_id[26:18]}, 32'h1FF);

    // R2 R3 R8: counting, gating and event wrap
    bus_wr(12'hC20, 32'hFFFFFFFF);
    bus_wr(12'h018, 32'hFFFFFFFE);
    bus_wr(12'h020, 32'h00000010);
    bus_wr(12'hC00, 32'h00000004);
    bus_wr(12'hC40, 32'h00000004);
    bus_wr(12'hE04, 32'h00000001);
    pulse(8'h0C, 3);
    bus_rd(12'h018, v); chk("R2 R3 counter2 wrapped", v, 32'h1);
    bus_rd(12'h020, v); chk("R2 counter3 disabled", v, 32'h10);
    bus_rd(12'hC80, v); chk("R3 overflow bit2", v, 32'h4);
    chk("R8 irq raised", {31'b0, irq}, 1);
    bus_wr(12'hE04, 32'h0);
    pulse(8'h04, 1);
    bus_rd(12'h018, v); chk("R2 global gate", v, 32'h1);

    // R7 clear
    bus_wr(12'hC80, 32'h4);
    bus_rd(12'hC80, v); chk("R7 cleared", v, 0);
    chk("R8 irq dropped", {31'b0, irq}, 0);

    // R9 event counter reset, one-shot
    bus_wr(12'hE04, 32'h2);
    bus_rd(12'h018, v); chk("R9 counter2 zeroed", v, 0);
    bus_rd(12'h010, v); chk("R9 counter1 zeroed", v, 0);
    bus_rd(12'hE04, v); chk("R9 bits read zero", v, 0);
    bus_rd(12'h0F8, v); chk("R9 cycle untouched", v, 32'hAAAA5555);

    // R7 clash: wrap and software clear in one cycle
    bus_wr(12'h008, 32'hFFFFFFFF);
    bus_wr(12'hC00, 32'h1);
    bus_wr(12'hCC0, 32'h1);
    bus_rd(12'hC80, v); chk("R7 set alias", v, 32'h1);
    bus_wr(12'hE04, 32'h1);
    @(negedge clk);
    evt_pulse = 8'h01;
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 12'hC80; cmd_wdata = 32'h1;
    @(negedge clk);
    evt_pulse = '0; cmd_valid = 1'b0; cmd_write = 1'b0;
    bus_rd(12'hC80, v); chk("R7 wrap beats clear", v, 32'h1);
    bus_rd(12'h008, v); chk("R3 counter0 zero", v, 0);
    bus_wr(12'hE04, 32'h0);
    bus_wr(12'hC80, 32'h1);

    // R4 carry low to high
    bus_wr(12'hC20, 32'hFFFFFFFF);
    bus_wr(12'h0F8, 32'hFFFFFFF0);
    bus_wr(12'h0FC, 32'h00000005);
    bus_wr(12'hC00, 32'h80000000);
    bus_wr(12'hE04, 32'h1);
    repeat (40) @(negedge clk);
    bus_wr(12'hE04, 32'h0);
    bus_rd(12'h0FC, v); chk("R4 carry into high", v, 32'h6);
    bus_rd(12'h0F8, v);
    chk("R4 low small", {31'b0, (v < 32'h100)}, 1);
    bus_rd(12'h0F8, v2); chk("R4 stopped", v2, v);
    bus_rd(12'hC80, v); chk("R3 no cycle overflow", v, 0);

    // R3 64-bit wrap of the cycle counter
    bus_wr(12'h0FC, 32'hFFFFFFFF);
    bus_wr(12'h0F8, 32'hFFFFFFF0);
    bus_wr(12'hC40, 32'h80000000);
    bus_wr(12'hE04, 32'h1);
    repeat (40) @(negedge clk);
    bus_wr(12'hE04, 32'h0);
    bus_rd(12'hC80, v); chk("R3 cycle overflow bit31", v, 32'h80000000);
    chk("R8 irq cycle", {31'b0, irq}, 1);
    bus_rd(12'h0FC, v); chk("R4 high wrapped", v, 0);

    // R9 cycle counter reset
    bus_wr(12'h0F8, 32'h55);
    bus_wr(12'hE04, 32'h4);
    bus_rd(12'h0F8, v); chk("R9 cycle zeroed", v, 0);

    // R8 masking
    bus_wr(12'hC60, 32'hFFFFFFFF);
    chk("R8 masked", {31'b0, irq}, 0);
    bus_wr(12'hC40, 32'h80000000);
    chk("R8 unmasked", {31'b0, irq}, 1);
    bus_wr(12'hC80, 32'hFFFFFFFF);
    chk("R8 flag cleared", {31'b0, irq}, 0);

    finish_run();
  end
endmodule